// File: doc/BRIEF.md
# Desaturation Fault Protection Sequencer

This block sequences the output side of an isolated IGBT gate driver. It turns a synchronous on/off command into drive controls for the output stage: a pull-up enable, a high-impedance control for the main stage, a slow soft-shutdown pull-down and an active Miller clamp. It also produces an active-low fault flag for the controller. The desaturation comparator is not examined while the gate is commanded off. After each turn-on it stays masked for a blanking window. It is only honoured while the output supply is reported healthy.

When a qualified desaturation trip occurs, the main stage is released to high impedance and the gate is discharged slowly through the soft-shutdown path. The fault flag goes low. A mute interval then follows, during which every command is ignored. After it, the command must stay low without a break for a reset interval before the fault clears. Any high command during that interval restarts the reset count. All three intervals are parameters counted in clock cycles. The Miller clamp engages whenever the gate is sensed near the negative rail and the stage is not driving high.

Top module: `desat_guard`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, the outputs are idle: drv_on_o=0, drv_hiz_o=0, ssd_en_o=0, fault_no=1.
- R2: With supply_ok_i=1 and no fault, drv_on_o goes to 1 in the cycle after cmd_i is sampled high. It goes to 0 in the cycle after cmd_i is sampled low.
- R3: While supply_ok_i=0 the driver never turns on. A drop of supply_ok_i while on turns drv_on_o off in the next cycle.
- R4: desat_i has no effect while the driver is off, or during the first BLANK_CYC cycles of each on period (the blanking window).
- R5: If desat_i is sampled high while on, after the blanking window and with cmd_i=1 and supply_ok_i=1, the next cycle shows drv_on_o=0, drv_hiz_o=1, ssd_en_o=1 and fault_no=0.
- R6: For MUTE_CYC cycles starting with the first faulted cycle, cmd_i has no effect at all.
- R7: After the mute interval, the fault clears only after RESET_CYC consecutive cycles in which cmd_i is sampled low. A high sample restarts that count. With cmd_i held low, fault_no is low for exactly MUTE_CYC+RESET_CYC cycles.
- R8: Once the fault clears, all fault outputs return to idle and the driver follows cmd_i again as in R2.
- R9: clamp_en_o equals gate_low_i whenever drv_on_o=0 (off or faulted), and is 0 whenever drv_on_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Synchronous gate-on command |
| desat_i | input | 1 | Desaturation comparator flag |
| supply_ok_i | input | 1 | Output supply above lockout threshold |
| gate_low_i | input | 1 | Gate sensed below clamp threshold |
| drv_on_o | output | 1 | Main stage pull-up enable (0 = sink when not high-Z) |
| drv_hiz_o | output | 1 | Main stage released to high impedance |
| ssd_en_o | output | 1 | Soft-shutdown pull-down enable |
| clamp_en_o | output | 1 | Miller clamp pull-down enable |
| fault_no | output | 1 | Fault flag, active low |

## Verification
A single-cycle desaturation pulse is swept across every offset from the cycle before turn-on to several cycles past the blanking window. This separates an off or still-blanked pulse, which must be ignored, from the first qualified sample, which must trip. A single high command pulse is then swept over every cycle of the fault. The measured fault length must be the fixed mute-plus-reset sum when the pulse falls inside the mute interval. It must grow by exactly the pulse position when the pulse falls inside the reset interval, which shows both that commands are ignored during mute and that the reset count restarts. Separate patterns toggle the supply and the gate-low sense to check the lockout and clamp behaviour.

// File: rtl/desat_pkg.sv
package desat_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_BLANK = 3'd1,
    ST_ON    = 3'd2,
    ST_MUTE  = 3'd3,
    ST_RST   = 3'd4
  } gd_state_e;
endpackage

// File: rtl/desat_cnt.sv
module desat_cnt #(
  parameter int unsigned W    = 4,
  parameter int unsigned MAXV = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= W'(MAXV)) else $error("count overrun"); // R7
endmodule

// File: rtl/desat_fsm.sv
module desat_fsm
  import desat_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 4,
  parameter int unsigned MUTE_CYC  = 6,
  parameter int unsigned RESET_CYC = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_i,
  input  logic      desat_i,
  input  logic      supply_ok_i,
  output gd_state_e st_o
);
  localparam int unsigned MAX_AB = (BLANK_CYC > MUTE_CYC) ? BLANK_CYC : MUTE_CYC;
  localparam int unsigned MAXC   = (MAX_AB > RESET_CYC) ? MAX_AB : RESET_CYC;
  localparam int unsigned CW     = $clog2(MAXC + 1);

  gd_state_e st_q, st_d;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;
  logic          run_ok;

  assign run_ok = cmd_i & supply_ok_i;

  desat_cnt #(.W(CW), .MAXV(MAXC)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b1;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_OFF:   if (run_ok) st_d = ST_BLANK;
      ST_BLANK: begin
        if (!run_ok)                          st_d = ST_OFF;
        else if (cnt == CW'(BLANK_CYC - 1))   st_d = ST_ON;
        else begin cnt_clr = 1'b0; cnt_inc = 1'b1; end
      end
      ST_ON: begin
        // command off wins: detection disabled when gate commanded low
        if (!run_ok)      st_d = ST_OFF;
        else if (desat_i) st_d = ST_MUTE;
      end
      ST_MUTE: begin
        if (cnt == CW'(MUTE_CYC - 1)) st_d = ST_RST;
        else begin cnt_clr = 1'b0; cnt_inc = 1'b1; end
      end
      ST_RST: begin
        if (cmd_i)                            cnt_clr = 1'b1;
        else if (cnt == CW'(RESET_CYC - 1))   st_d = ST_OFF;
        else begin cnt_clr = 1'b0; cnt_inc = 1'b1; end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  AST_SUPPLY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && st_q != ST_MUTE && st_q != ST_RST) |=> (st_q == ST_OFF)) else $error("on without supply"); // R3
  AST_OFF_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF) |=> (st_q != ST_MUTE)) else $error("trip while off"); // R4
  AST_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && run_ok && desat_i) |=> (st_q == ST_MUTE)) else $error("missed trip"); // R5
  AST_MUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MUTE) |=> (st_q == ST_MUTE || st_q == ST_RST)) else $error("left mute early"); // R6
  AST_NO_EARLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RST && cmd_i) |=> (st_q == ST_RST)) else $error("cleared with cmd high"); // R7
endmodule

// File: rtl/desat_out.sv
module desat_out
  import desat_pkg::*;
(
  input  gd_state_e st_i,
  input  logic      gate_low_i,
  output logic      drv_on_o,
  output logic      drv_hiz_o,
  output logic      ssd_en_o,
  output logic      clamp_en_o,
  output logic      fault_no
);
  logic faulted;

  assign faulted    = (st_i == ST_MUTE) || (st_i == ST_RST);
  assign drv_on_o   = (st_i == ST_BLANK) || (st_i == ST_ON);
  assign drv_hiz_o  = faulted;
  assign ssd_en_o   = faulted;
  assign fault_no   = ~faulted;
  assign clamp_en_o = gate_low_i & ~drv_on_o;
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import desat_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 4,
  parameter int unsigned MUTE_CYC  = 6,
  parameter int unsigned RESET_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic desat_i,
  input  logic supply_ok_i,
  input  logic gate_low_i,
  output logic drv_on_o,
  output logic drv_hiz_o,
  output logic ssd_en_o,
  output logic clamp_en_o,
  output logic fault_no
);
  gd_state_e st;

  desat_fsm #(
    .BLANK_CYC(BLANK_CYC),
    .MUTE_CYC (MUTE_CYC),
    .RESET_CYC(RESET_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .desat_i    (desat_i),
    .supply_ok_i(supply_ok_i),
    .st_o       (st)
  );

  desat_out u_out (
    .st_i      (st),
    .gate_low_i(gate_low_i),
    .drv_on_o  (drv_on_o),
    .drv_hiz_o (drv_hiz_o),
    .ssd_en_o  (ssd_en_o),
    .clamp_en_o(clamp_en_o),
    .fault_no  (fault_no)
  );

  AST_CLAMP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_en_o |-> !drv_on_o) else $error("clamp fights pull-up"); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> (drv_hiz_o && ssd_en_o && !drv_on_o)) else $error("fault outputs split"); // R5
  AST_FAULT_CMD_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_no && $past(!fault_no)) |-> !drv_on_o) else $error("drive during fault"); // R6
endmodule

// File: tb/desat_guard_tb.sv
module desat_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 4;
  localparam int MUTE  = 6;
  localparam int RST   = 5;

  logic clk = 1'b0;
  logic rst_ni, cmd, desat, sup, glow;
  logic drv_on, drv_hiz, ssd_en, clamp_en, fault_n;
  int   n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desat_guard #(.BLANK_CYC(BLANK), .MUTE_CYC(MUTE), .RESET_CYC(RST)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .desat_i(desat),
    .supply_ok_i(sup), .gate_low_i(glow),
    .drv_on_o(drv_on), .drv_hiz_o(drv_hiz), .ssd_en_o(ssd_en),
    .clamp_en_o(clamp_en), .fault_no(fault_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // cmd high until ON, pulse desat; returns at first faulted cycle
  task automatic do_trip();
    nxt(); cmd = 1'b1; desat = 1'b0;
    repeat (BLANK + 1) nxt();
    desat = 1'b1;
    nxt(); desat = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; cmd = 1'b0; desat = 1'b0; sup = 1'b1; glow = 1'b0;
    repeat (2) nxt();
    check("R1 drv_on", drv_on, 0);
    check("R1 hiz", drv_hiz, 0);
    check("R1 ssd", ssd_en, 0);
    check("R1 fault_n", fault_n, 1);
    rst_ni = 1'b1;
    nxt();
    check("R1 fault_n after release", fault_n, 1);

    // R2 follow command
    cmd = 1'b1; nxt();
    check("R2 on", drv_on, 1);
    cmd = 1'b0; nxt();
    check("R2 off", drv_on, 0);

    // R3 supply lockout
    sup = 1'b0; cmd = 1'b1;
    for (int i = 0; i < 3; i++) begin nxt(); check("R3 locked", drv_on, 0); end
    sup = 1'b1; nxt();
    check("R3 on after supply", drv_on, 1);
    sup = 1'b0; nxt();
    check("R3 drop", drv_on, 0);
    cmd = 1'b0; sup = 1'b1; nxt();

    // R4 desat while off
    desat = 1'b1;
    for (int i = 0; i < 3; i++) begin nxt(); check("R4 off ignore", fault_n, 1); end
    desat = 1'b0; nxt();

    // R4/R5 sweep desat pulse offset k relative to command rise
    for (int k = 0; k <= BLANK + 3; k++) begin
      bit trip;
      trip = (k >= BLANK + 1);
      for (int n = 0; n <= k; n++) begin
        cmd = 1'b1; desat = (n == k);
        nxt();
      end
      desat = 1'b0;
      check(trip ? "R5 trip hiz" : "R4 blank hiz", drv_hiz, trip);
      check(trip ? "R5 trip fault_n" : "R4 blank fault_n", fault_n, !trip);
      check(trip ? "R5 trip ssd" : "R4 blank ssd", ssd_en, trip);
      check(trip ? "R5 trip drv" : "R4 blank drv", drv_on, !trip);
      cmd = 1'b0;
      repeat (trip ? MUTE + RST + 2 : 2) nxt();
      check("R8 idle after", fault_n, 1);
    end

    // R6/R7 sweep a one-cycle command pulse over the fault
    glow = 1'b1;
    for (int p = 0; p < MUTE + RST; p++) begin
      int dur, exp_dur;
      do_trip();
      check("R9 clamp in fault", clamp_en, 1);
      dur = 0;
      for (int i = 0; i < 64; i++) begin
        if (fault_n) break;
        dur++;
        check("R6 no drive in fault", drv_on, 0);
        cmd = (i == p);
        nxt();
      end
      cmd = 1'b0;
      exp_dur = (p < MUTE) ? MUTE + RST : p + 1 + RST;
      check(p < MUTE ? "R6 mute ignores cmd" : "R7 reset restart", dur, exp_dur);
      check("R8 hiz clear", drv_hiz, 0);
      check("R9 clamp off state", clamp_en, 1);
      cmd = 1'b1; nxt();
      check("R8 follows again", drv_on, 1);
      check("R9 clamp while on", clamp_en, 0);
      cmd = 1'b0; nxt();
      check("R8 off again", drv_on, 0);
    end
    glow = 1'b0; nxt();
    check("R9 clamp no sense", clamp_en, 0);

    finish_run();
  end
endmodule